// File: doc/BRIEF.md
# Fixed-Frequency Voltage-Mode Pulse Modulator with Current-Limit Blanking

This block turns an unsigned error word into a gate-on pulse that repeats at a fixed rate taken from the system clock. A free-running tick counter marks the period. The gate turns on at tick 0 of each period and turns off at the first tick that reaches an off-threshold. That threshold comes from the error word, which is captured once per period. A larger error gives a shorter pulse. Below an offset, the pulse stays at the maximum-duty length. The pulse never gets shorter than a minimum on-time floor.

A current-limit comparator flag can end the pulse early. The flag is ignored during a blanking window of the first ticks of every period, and once it acts the gate stays off until the next period starts. A sequencer enable forces the gate off. A pulse can only begin again at a later period start. The period length, blanking length, minimum and maximum on-times, the error offset and the gain shift are all tick-count parameters.

Top module: `vm_pwm_core`

## Requirements
- R1: While `rst_n` is low, `gate_o` is 0. After release the tick counter starts at 0, and `gate_o` stays 0 until the first period start that follows the release.
- R2: The counter steps through ticks 0 to PERIOD_TICKS-1 and then wraps. `gate_o` rises only at tick 0 and only when `en_i` was 1 at the clock edge that entered tick 0.
- R3: If the error word captured for a period is at or below ERR_OFFSET, the pulse lasts MAX_ON_TICKS ticks.
- R4: Above the offset, the on-time is MAX_ON_TICKS - ((err - ERR_OFFSET) >> GAIN_SHIFT) ticks, so the duty falls linearly as the error rises.
- R5: The on-time never drops below MIN_ON_TICKS. Any error whose reduction reaches MAX_ON_TICKS-MIN_ON_TICKS gives exactly MIN_ON_TICKS.
- R6: `gate_o` is never high at a tick at or beyond MAX_ON_TICKS.
- R7: Suppose `cl_i` is 1 at an edge where the gate is on and the tick is BLANK_TICKS or later. Then `gate_o` is 0 from the next tick and stays 0 until the next period start.
- R8: `cl_i` has no effect at ticks 0 to BLANK_TICKS-1. A pulse that sees the flag only there keeps its full length.
- R9: `en_i` low at an edge makes `gate_o` 0 from the next tick. Raising `en_i` in the middle of a period does not restart the pulse before the next period start.
- R10: The error word is sampled only at the edge that enters tick 0. Changing it during a period does not change that period's pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Sequencer enable; low forces the gate off |
| err_i | input | ERR_W | Unsigned error word; larger means shorter pulse |
| cl_i | input | 1 | Current-limit comparator flag, synchronous to clk |
| gate_o | output | 1 | Gate-on command |

## Verification
The bench builds the block with a 50-tick period, 4 blanking ticks, a 3-tick floor, a 33-tick maximum, an offset of 20 and a gain shift of 1. With these values every period is short, so the offset knee, the linear slope with its halving, and the point where the floor takes over can all be reached with small error words. Because the blanking window is short, the current-limit flag can be placed at its last ignored tick and at its first active tick. The flag can also land after a floor-length pulse has already ended. Enable is dropped in the middle of a pulse and raised again in the middle of a period. The error word is changed in the middle of a period to show that it only takes effect at the next capture.

// File: rtl/vm_pwm_pkg.sv
package vm_pwm_pkg;

   // Reasons the gate latch is cleared in a given cycle
   typedef struct packed {
      logic en_drop;
      logic limit;
      logic thr_hit;
   } clr_src_t;

   function automatic int unsigned cnt_width(input int unsigned ticks);
      return (ticks <= 2) ? 1 : $clog2(ticks);
   endfunction

endpackage

// File: rtl/vm_pwm_ramp.sv
module vm_pwm_ramp #(
   parameter int unsigned PERIOD_TICKS = 1000,
   parameter int unsigned CNT_W        = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

   always_comb begin
      wrap_o  = (cnt_q == LAST);
      cnt_nxt = wrap_o ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   assert_wrap_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/vm_pwm_thresh.sv
module vm_pwm_thresh #(
   parameter int unsigned ERR_W        = 10,
   parameter int unsigned CNT_W        = 10,
   parameter int unsigned ERR_OFFSET   = 160,
   parameter int unsigned GAIN_SHIFT   = 0,
   parameter int unsigned MIN_ON_TICKS = 17,
   parameter int unsigned MAX_ON_TICKS = 670
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [ERR_W-1:0] err_i,
   output logic [CNT_W-1:0] thr_o
);

   localparam logic [31:0]      SPAN  = 32'(MAX_ON_TICKS - MIN_ON_TICKS);
   localparam logic [ERR_W-1:0] OFS   = ERR_W'(ERR_OFFSET);
   localparam logic [CNT_W-1:0] T_MAX = CNT_W'(MAX_ON_TICKS);
   localparam logic [CNT_W-1:0] T_MIN = CNT_W'(MIN_ON_TICKS);

   logic [ERR_W-1:0] err_q;
   logic [ERR_W-1:0] excess;
   logic [ERR_W-1:0] drop;

   // error captured once per period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err_q <= '0;
      else if (load_i) err_q <= err_i;
   end

   always_comb begin
      excess = (err_q > OFS) ? (err_q - OFS) : '0;
   end

   generate
      if (GAIN_SHIFT == 0) begin : g_unity
         always_comb drop = excess;
      end else begin : g_shift
         always_comb drop = excess >> GAIN_SHIFT;
      end
   endgenerate

   always_comb begin
      if (32'(drop) >= SPAN) thr_o = T_MIN;
      else                   thr_o = T_MAX - CNT_W'(drop);
   end

   assert_thr_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      thr_o >= T_MIN);

   assert_thr_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
      thr_o <= T_MAX);

   assert_err_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(err_q));

endmodule

// File: rtl/vm_pwm_blank.sv
module vm_pwm_blank #(
   parameter int unsigned BLANK_TICKS = 15,
   parameter int unsigned CNT_W       = 10
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             gate_i,
   input  logic             cl_i,
   output logic             trip_o
);

   generate
      if (BLANK_TICKS == 0) begin : g_noblank
         always_comb trip_o = cl_i & gate_i;
      end else begin : g_blank
         localparam logic [CNT_W-1:0] B = CNT_W'(BLANK_TICKS);
         always_comb trip_o = cl_i & gate_i & (cnt_i >= B);
      end
   endgenerate

endmodule

// File: rtl/vm_pwm_latch.sv
module vm_pwm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic gate_o
);

   // clear wins over set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     gate_o <= 1'b0;
      else if (clr_i) gate_o <= 1'b0;
      else if (set_i) gate_o <= 1'b1;
   end

   assert_clear_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !gate_o);

endmodule

// File: rtl/vm_pwm_core.sv
module vm_pwm_core #(
   parameter int unsigned PERIOD_TICKS = 1000,
   parameter int unsigned ERR_W        = 10,
   parameter int unsigned ERR_OFFSET   = 160,
   parameter int unsigned GAIN_SHIFT   = 0,
   parameter int unsigned MIN_ON_TICKS = 17,
   parameter int unsigned MAX_ON_TICKS = 670,
   parameter int unsigned BLANK_TICKS  = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [ERR_W-1:0] err_i,
   input  logic             cl_i,
   output logic             gate_o
);
   import vm_pwm_pkg::*;

   localparam int unsigned CNT_W = cnt_width(PERIOD_TICKS);

   generate
      if (PERIOD_TICKS < 4)
         $error("period must be at least 4 ticks");
      if (MAX_ON_TICKS >= PERIOD_TICKS)
         $error("maximum on-time must be shorter than the period");
      if (MIN_ON_TICKS < 1 || MIN_ON_TICKS > MAX_ON_TICKS)
         $error("minimum on-time must lie in 1..maximum on-time");
      if (GAIN_SHIFT >= ERR_W)
         $error("gain shift must be narrower than the error word");
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             wrap;
   logic [CNT_W-1:0] thr;
   logic             trip;
   logic             set_req;
   clr_src_t         clr_src;

   vm_pwm_ramp #(.PERIOD_TICKS(PERIOD_TICKS), .CNT_W(CNT_W)) u_ramp (
      .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wrap_o(wrap));

   vm_pwm_thresh #(
      .ERR_W(ERR_W), .CNT_W(CNT_W), .ERR_OFFSET(ERR_OFFSET), .GAIN_SHIFT(GAIN_SHIFT),
      .MIN_ON_TICKS(MIN_ON_TICKS), .MAX_ON_TICKS(MAX_ON_TICKS)
   ) u_thresh (
      .clk(clk), .rst_n(rst_n), .load_i(wrap), .err_i(err_i), .thr_o(thr));

   vm_pwm_blank #(.BLANK_TICKS(BLANK_TICKS), .CNT_W(CNT_W)) u_blank (
      .cnt_i(cnt_q), .gate_i(gate_o), .cl_i(cl_i), .trip_o(trip));

   always_comb begin
      set_req         = en_i & wrap;
      clr_src.en_drop = ~en_i;
      clr_src.limit   = trip;
      clr_src.thr_hit = ~wrap & (cnt_nxt >= thr);
   end

   vm_pwm_latch u_latch (
      .clk(clk), .rst_n(rst_n), .set_i(set_req), .clr_i(|clr_src), .gate_o(gate_o));

   assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> (cnt_q == '0));

   assert_max_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gate_o |-> (cnt_q < CNT_W'(MAX_ON_TICKS)));

   assert_limit_cuts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o && cl_i && cnt_q >= CNT_W'(BLANK_TICKS)) |=> !gate_o);

   assert_enable_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !gate_o);

   assert_floor_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o && cnt_q < CNT_W'(MIN_ON_TICKS - 1) && en_i && !trip) |=> gate_o);

endmodule

// File: tb/vm_pwm_core_tb_top.sv
module vm_pwm_core_tb_top;

   localparam int P     = 50;
   localparam int EW    = 8;
   localparam int OFS   = 20;
   localparam int SH    = 1;
   localparam int MINON = 3;
   localparam int MAXON = 33;
   localparam int BLK   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [EW-1:0] err = '0;
   logic          cl = 1'b0;
   logic          gate;

   int    n_checks = 0;
   int    n_errs = 0;
   bit    done = 0;
   string cur_req = "R1";

   // reference model state
   int m_cnt = 0;
   int m_err = 0;
   bit m_gate = 0;

   always #4 clk = ~clk;

   vm_pwm_core #(
      .PERIOD_TICKS(P), .ERR_W(EW), .ERR_OFFSET(OFS), .GAIN_SHIFT(SH),
      .MIN_ON_TICKS(MINON), .MAX_ON_TICKS(MAXON), .BLANK_TICKS(BLK)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en), .err_i(err), .cl_i(cl), .gate_o(gate));

   function automatic int on_len(input int e);
      int d;
      if (e <= OFS) return MAXON;
      d = (e - OFS) >> SH;
      if (d >= MAXON - MINON) return MINON;
      return MAXON - d;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_err = 0; m_gate = 0;
      end else begin
         int ncnt;
         bit trip;
         int thr;
         ncnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
         trip = cl && m_gate && (m_cnt >= BLK);
         thr  = on_len(m_err);
         if (!en || trip || (ncnt != 0 && ncnt >= thr)) m_gate = 0;
         else if (ncnt == 0) m_gate = 1;
         if (ncnt == 0) m_err = int'(err);
         m_cnt = ncnt;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) check(gate == m_gate, cur_req, int'(gate), int'(m_gate));
   end

   // mode: 0 plain, 1 pulse cl at tick, 2 change err at tick, 3 drop en at tick and raise at tick2
   task automatic measure(input int e, input int mode, input int t1, input int t2,
                          input int exp, input string req);
      int hi;
      err = EW'(e);
      cur_req = req;
      @(negedge clk);
      while (m_cnt != 0) @(negedge clk);
      hi = 0;
      for (int i = 0; i < P; i++) begin
         if (gate) hi++;
         if (mode == 1) cl = (i == t1);
         if (mode == 2 && i == t1) err = '1;
         if (mode == 3 && i == t1) en = 1'b0;
         if (mode == 3 && i == t2) en = 1'b1;
         @(negedge clk);
      end
      cl = 1'b0;
      check(hi == exp, req, hi, exp);
   endtask

   initial begin
      en = 1'b1;
      repeat (5) @(negedge clk);
      check(gate == 1'b0, "R1", int'(gate), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(gate == 1'b0, "R1", int'(gate), 0);

      measure(0,   0, 0, 0, on_len(0),   "R3");
      check(on_len(0) == 33, "R3", on_len(0), 33);
      measure(20,  0, 0, 0, 33, "R3");
      measure(21,  0, 0, 0, 33, "R4");
      measure(22,  0, 0, 0, 32, "R4");
      measure(40,  0, 0, 0, 23, "R4");
      measure(78,  0, 0, 0, 4,  "R4");
      measure(80,  0, 0, 0, 3,  "R5");
      measure(255, 0, 0, 0, 3,  "R5");
      measure(0,   0, 0, 0, 33, "R6");

      measure(0,  1, 2,  0, 33, "R8");
      measure(0,  1, 3,  0, 33, "R8");
      measure(0,  1, 4,  0, 5,  "R7");
      measure(0,  1, 10, 0, 11, "R7");
      measure(80, 1, 3,  0, 3,  "R7");

      measure(30, 2, 5,  0, 28, "R10");
      measure(30, 0, 0,  0, 28, "R10");

      measure(0,  3, 5,  10, 6,  "R9");
      en = 1'b0;
      measure(0,  3, 60, 2,  0,  "R9");
      measure(0,  0, 0,  0, 33, "R2");

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

endmodule